// File: doc/BRIEF.md
# Upset Injection Comparison Rig

This block is a test rig for measuring how well a hardened pattern-detecting state machine survives state-bit upsets. It drives one registered serial stream to two external detectors. One is a golden detector that is never disturbed. The other is the detector under test, whose state register gets single-bit flips. The rig then compares the two detectors' match flags in the same clock cycle and keeps two tallies: matches the detector under test missed, and matches it reported that the golden detector did not.

The stream alternates frames that carry the key with frames that differ from the key in exactly one bit. The differing bit moves on every near-miss frame, so false matches are as likely as possible. A 16-bit LFSR sets both when each upset happens and which lane of a 16-lane flip bus it hits. Lanes at or above the width of the detector under test are dropped, so a machine whose state is n bits wide receives n/16 of the faults. A mode input chooses the target of the flip. One bus feeds the next-state value, which is the flip before the register. The other bus is XORed onto the register output, which is the flip after it.

Top module: `seu_compare_rig`

## Requirements
- R1: While `rst` is high at a clock edge, both counts, both flip buses and `stream_bit` become zero.
- R2: Each enabled cycle, one bit of a 16-bit frame appears on `stream_bit` after the edge, most significant bit first. Frames alternate: the key first (default 16'hB38E), then a near miss equal to key XOR (1 << k). k starts at 0 and rises by one, modulo 16, after each near-miss frame.
- R3: When `en` is low, the stream, the LFSR, the fault timer and both counts hold, and both flip buses are zero after that edge.
- R4: The LFSR resets to 16'hACE1 and advances once per enabled cycle to {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R5: The effective gap G is 199 when `gap_sel` is 0, 8 when `gap_sel` is 1 to 7, and `gap_sel` otherwise. The first fault fires on the 199th enabled edge after reset. Each later fault follows the previous one by G+j, then G-j, alternating, where j = LFSR[2:0] at the firing edge. The mean interval is therefore G.
- R6: A fault flips lane LFSR[7:4] (sampled at the firing edge) for one cycle. If that lane is not below DUT_W (default 8), the fault is dropped. At most one lane is high at a time.
- R7: When `post_reg_mode` is 0 at the firing edge, the pulse goes to `flip_pre`. When it is 1, the pulse goes to `flip_post`. The other bus stays zero.
- R8: An enabled cycle with `ref_hit`=1 and `dut_hit`=0 raises `miss_count` by one after the edge.
- R9: An enabled cycle with `dut_hit`=1 and `ref_hit`=0 raises `false_count` by one after the edge.
- R10: Both counts saturate at 65535.
- R11: An enabled cycle in which `ref_hit` equals `dut_hit` changes neither count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes the rig |
| gap_sel | input | 16 | Requested mean clocks between faults; 0 selects the default |
| post_reg_mode | input | 1 | 0 flips before the state register, 1 after it |
| ref_hit | input | 1 | Match flag of the golden detector |
| dut_hit | input | 1 | Match flag of the detector under test |
| stream_bit | output | 1 | Registered serial bit fed to both detectors |
| flip_pre | output | 16 | One-hot flip applied to the next-state value |
| flip_post | output | 16 | One-hot flip applied to the state register output |
| miss_count | output | 16 | Saturating count of missed matches |
| false_count | output | 16 | Saturating count of false matches |

## Verification
Every output sits one register away from its cause. The stream bit, a flip pulse and a count step all appear right after the enabled edge that produced them. The flip pulse belongs to the edge where the fault timer reached one. The bench model updates on that same rising edge from inputs driven at the previous falling edge, and it compares all five outputs at the following falling edge. Each comparison therefore lands exactly one register delay after its stimulus. Explicit checks also cover the reset values, a frozen interval, a run of agreeing match flags and counter saturation.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int FAULT_LANES = 16;
    localparam int LANE_W      = 4;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam logic [15:0] MIN_GAP   = 16'd8;

    typedef enum logic {FRAME_KEY = 1'b0, FRAME_NEAR = 1'b1} frame_kind_e;

    typedef struct packed {
        logic              fire;
        logic [LANE_W-1:0] lane;
    } fault_evt_t;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [16:0] gap_eff(input logic [15:0] req, input logic [15:0] dflt);
        if (req == 16'd0)       return {1'b0, dflt};
        else if (req < MIN_GAP) return {1'b0, MIN_GAP};
        else                    return {1'b0, req};
    endfunction
endpackage

// File: rtl/scr_stream_gen.sv
module scr_stream_gen
    import scr_pkg::*;
#(
    parameter int          PAT_W = 16,
    parameter logic [15:0] KEY   = 16'hB38E
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic bit_o
);
    localparam int IDX_W = $clog2(PAT_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAT_W - 1);

    logic [IDX_W-1:0] bit_idx, rot;
    frame_kind_e      kind;
    logic [PAT_W-1:0] frame;

    always_comb begin
        frame = KEY[PAT_W-1:0];
        if (kind == FRAME_NEAR) frame = frame ^ (PAT_W'(1) << rot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx <= '0;
            rot     <= '0;
            kind    <= FRAME_KEY;
            bit_o   <= 1'b0;
        end else if (en) begin
            bit_o <= frame[LAST - bit_idx];
            if (bit_idx == LAST) begin
                bit_idx <= '0;
                if (kind == FRAME_NEAR) begin
                    kind <= FRAME_KEY;
                    rot  <= (rot == LAST) ? '0 : rot + 1'b1;
                end else begin
                    kind <= FRAME_NEAR;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scr_fault_gen.sv
module scr_fault_gen
    import scr_pkg::*;
#(
    parameter logic [15:0] DEF_GAP = 16'd199
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [15:0] gap_sel,
    output fault_evt_t  evt
);
    logic [15:0] lfsr;
    logic [16:0] timer, eff, jit, reload;
    logic        plus;

    always_comb begin
        eff    = gap_eff(gap_sel, DEF_GAP);
        jit    = {14'd0, lfsr[2:0]};
        reload = plus ? eff + jit : eff - jit;
        evt.fire = en && (timer <= 17'd1);
        evt.lane = lfsr[7:4];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr  <= LFSR_SEED;
            timer <= {1'b0, DEF_GAP};
            plus  <= 1'b1;
        end else if (en) begin
            lfsr <= lfsr_step(lfsr);
            if (evt.fire) begin
                timer <= reload;
                plus  <= ~plus;
            end else begin
                timer <= timer - 17'd1;
            end
        end
    end
endmodule

// File: rtl/scr_sat_ctr.sv
module scr_sat_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                       count <= '0;
        else if (bump && count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/seu_compare_rig.sv
module seu_compare_rig
    import scr_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter int          DUT_W   = 8,
    parameter int          PAT_W   = 16,
    parameter logic [15:0] KEY     = 16'hB38E,
    parameter logic [15:0] DEF_GAP = 16'd199
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [15:0]            gap_sel,
    input  logic                   post_reg_mode,
    input  logic                   ref_hit,
    input  logic                   dut_hit,
    output logic                   stream_bit,
    output logic [FAULT_LANES-1:0] flip_pre,
    output logic [FAULT_LANES-1:0] flip_post,
    output logic [CNT_W-1:0]       miss_count,
    output logic [CNT_W-1:0]       false_count
);
    fault_evt_t             evt;
    logic [FAULT_LANES-1:0] lane_hit;
    logic                   miss_ev, false_ev;

    scr_stream_gen #(.PAT_W(PAT_W), .KEY(KEY)) u_stream (
        .clk(clk), .rst(rst), .en(en), .bit_o(stream_bit)
    );

    scr_fault_gen #(.DEF_GAP(DEF_GAP)) u_fault (
        .clk(clk), .rst(rst), .en(en), .gap_sel(gap_sel), .evt(evt)
    );

    for (genvar i = 0; i < FAULT_LANES; i++) begin : g_lane
        if (i < DUT_W) begin : g_live
            assign lane_hit[i] = evt.fire && (evt.lane == LANE_W'(i));
        end else begin : g_dead
            assign lane_hit[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            flip_pre  <= '0;
            flip_post <= '0;
        end else begin
            flip_pre  <= post_reg_mode ? '0 : lane_hit;
            flip_post <= post_reg_mode ? lane_hit : '0;
        end
    end

    assign miss_ev  = en && ref_hit && !dut_hit;
    assign false_ev = en && dut_hit && !ref_hit;

    scr_sat_ctr #(.CNT_W(CNT_W)) u_miss (
        .clk(clk), .rst(rst), .bump(miss_ev), .count(miss_count)
    );
    scr_sat_ctr #(.CNT_W(CNT_W)) u_false (
        .clk(clk), .rst(rst), .bump(false_ev), .count(false_count)
    );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int CNT_W = 16,
    parameter int DUT_W = 8,
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             ref_hit,
    input logic             dut_hit,
    input logic             stream_bit,
    input logic [LANES-1:0] flip_pre,
    input logic [LANES-1:0] flip_post,
    input logic [CNT_W-1:0] miss_count,
    input logic [CNT_W-1:0] false_count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r7_single_bus: assert property (@(posedge clk) disable iff (rst)
        !((|flip_pre) && (|flip_post)));
    a_r6_one_lane: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flip_pre | flip_post));
    a_r6_lane_bound: assert property (@(posedge clk) disable iff (rst)
        ((flip_pre | flip_post) >> DUT_W) == '0);
    a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(stream_bit) && $stable(miss_count) && $stable(false_count)
                && flip_pre == '0 && flip_post == '0);
    a_r8_miss_step: assert property (@(posedge clk) disable iff (rst)
        (en && ref_hit && !dut_hit && miss_count != TOP) |=> miss_count == $past(miss_count) + 1'b1);
    a_r9_false_step: assert property (@(posedge clk) disable iff (rst)
        (en && dut_hit && !ref_hit && false_count != TOP) |=> false_count == $past(false_count) + 1'b1);
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (miss_count == TOP) |=> (miss_count == TOP));
    a_r10_no_overflow_fp: assert property (@(posedge clk) disable iff (rst)
        (false_count == TOP) |=> (false_count == TOP));
    a_r11_agree_idle: assert property (@(posedge clk) disable iff (rst)
        (ref_hit == dut_hit) |=> $stable(miss_count) && $stable(false_count));
endmodule

bind seu_compare_rig scr_checker #(.CNT_W(CNT_W), .DUT_W(DUT_W), .LANES(scr_pkg::FAULT_LANES)) u_chk (
    .clk(clk), .rst(rst), .en(en), .ref_hit(ref_hit), .dut_hit(dut_hit),
    .stream_bit(stream_bit), .flip_pre(flip_pre), .flip_post(flip_post),
    .miss_count(miss_count), .false_count(false_count)
);

// File: tb/seu_compare_rig_bench.sv
`timescale 1ns/1ps
module seu_compare_rig_bench;
    localparam int KEYV = 16'hB38E;
    localparam int DW   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] gap_sel = 16'd0;
    logic        post_reg_mode = 1'b0;
    logic        ref_hit = 1'b0;
    logic        dut_hit = 1'b0;
    logic        stream_bit;
    logic [15:0] flip_pre, flip_post, miss_count, false_count;

    seu_compare_rig u_seu_compare_rig (
        .clk(clk), .rst(rst), .en(en), .gap_sel(gap_sel), .post_reg_mode(post_reg_mode),
        .ref_hit(ref_hit), .dut_hit(dut_hit), .stream_bit(stream_bit),
        .flip_pre(flip_pre), .flip_post(flip_post),
        .miss_count(miss_count), .false_count(false_count)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    // behavioural model state
    int e_lfsr, e_timer, e_bidx, e_rot, e_miss, e_fals;
    bit e_plus, e_near, e_ser;
    int e_pre, e_post;
    int faults_seen = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int frame, eff, j, ln, bus, fb;
        if (rst) begin
            e_lfsr = 16'hACE1; e_timer = 199; e_plus = 1; e_bidx = 0; e_rot = 0;
            e_near = 0; e_ser = 0; e_pre = 0; e_post = 0; e_miss = 0; e_fals = 0;
            started = 1;
        end else if (en) begin
            frame = e_near ? (KEYV ^ (1 << e_rot)) : KEYV;
            e_ser = (frame >> (15 - e_bidx)) & 1;
            if (e_bidx == 15) begin
                e_bidx = 0;
                if (e_near) e_rot = (e_rot + 1) % 16;
                e_near = !e_near;
            end else e_bidx++;
            eff = (gap_sel == 0) ? 199 : (gap_sel < 8) ? 8 : int'(gap_sel);
            bus = 0;
            if (e_timer <= 1) begin
                j = e_lfsr & 7;
                e_timer = e_plus ? eff + j : eff - j;
                e_plus = !e_plus;
                ln = (e_lfsr >> 4) & 15;
                if (ln < DW) bus = 1 << ln;
            end else e_timer--;
            e_pre  = post_reg_mode ? 0 : bus;
            e_post = post_reg_mode ? bus : 0;
            fb = ((e_lfsr >> 15) ^ (e_lfsr >> 13) ^ (e_lfsr >> 12) ^ (e_lfsr >> 10)) & 1;
            e_lfsr = ((e_lfsr << 1) | fb) & 16'hFFFF;
            if (ref_hit && !dut_hit && e_miss < 65535) e_miss++;
            if (dut_hit && !ref_hit && e_fals < 65535) e_fals++;
        end else begin
            e_pre = 0; e_post = 0;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 stream bit", int'(stream_bit), int'(e_ser));
            check("R4 R5 R6 R7 flip_pre", int'(flip_pre), e_pre);
            check("R4 R5 R6 R7 flip_post", int'(flip_post), e_post);
            check("R8 R10 miss_count", int'(miss_count), e_miss);
            check("R9 R10 false_count", int'(false_count), e_fals);
            if (flip_pre != 0 || flip_post != 0) faults_seen++;
        end
    end

    task automatic cyc(input int n, input bit rnd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rnd) begin
                ref_hit = $urandom_range(0, 1);
                dut_hit = $urandom_range(0, 1);
            end
        end
    endtask

    initial begin
        logic [15:0] hm, hf;
        logic        hs;
        cyc(3, 0);
        // R1 reset values
        check("R1 stream reset", int'(stream_bit), 0);
        check("R1 counts reset", int'(miss_count | false_count), 0);
        check("R1 flips reset", int'(flip_pre | flip_post), 0);
        rst = 0; en = 1;
        cyc(2500, 1);
        check("R5 faults occurred with default gap", int'(faults_seen > 0), 1);
        post_reg_mode = 1; gap_sel = 16'd3;
        cyc(600, 1);
        gap_sel = 16'd20;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            en = $urandom_range(0, 3) != 0;
            post_reg_mode = $urandom_range(0, 1);
            ref_hit = $urandom_range(0, 1);
            dut_hit = $urandom_range(0, 1);
        end
        // R3 frozen interval
        @(negedge clk); en = 0; ref_hit = 1; dut_hit = 0;
        @(negedge clk);
        hs = stream_bit; hm = miss_count; hf = false_count;
        cyc(30, 0);
        check("R3 stream held", int'(stream_bit), int'(hs));
        check("R3 miss held", int'(miss_count), int'(hm));
        check("R3 false held", int'(false_count), int'(hf));
        check("R3 flips quiet", int'(flip_pre | flip_post), 0);
        // R11 agreeing flags
        en = 1; ref_hit = 1; dut_hit = 1;
        @(negedge clk);
        hm = miss_count; hf = false_count;
        cyc(20, 0);
        ref_hit = 0; dut_hit = 0;
        cyc(20, 0);
        check("R11 miss unchanged", int'(miss_count), int'(hm));
        check("R11 false unchanged", int'(false_count), int'(hf));
        // R10 saturation
        gap_sel = 16'd0;
        ref_hit = 1; dut_hit = 0;
        cyc(65600, 0);
        check("R10 miss saturates", int'(miss_count), 65535);
        ref_hit = 0; dut_hit = 1;
        cyc(65600, 0);
        check("R10 false saturates", int'(false_count), 65535);
        check("R10 miss still saturated", int'(miss_count), 65535);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule